// File: doc/BRIEF.md
# Layer-Steering Packet Injection Switch

This block sits below a column of stacked tiles and joins their injection traffic to the routers on every layer. Each of `N_IN` tile inputs delivers fixed-length packets as a stream of flits. For each packet the block picks a destination layer at random, so that the vertical leg of every route is one hop at injection and the load spreads evenly over the layers. The block then claims a virtual channel at that layer's router and forwards the packet's flits through a per-layer output.

Every input has a small flit buffer. A packet's head flit waits there until its chosen layer has a virtual channel that is idle and has room downstream for a whole packet. After that, the flits of the packet compete with other inputs for that layer's output under round-robin arbitration. Flow control uses credits. One counter per layer and virtual channel goes down on each flit sent and up on each credit the layer router returns. Flits are opaque to the block, and their bits pass through unchanged.

Top module: `lm_inject_demux`

## Requirements
- R1: After reset every `out_valid_o` bit is 0, every `in_ready_o` bit is 1, and every credit counter holds `VC_DEPTH`.
- R2: Each input stores up to `BUF_DEPTH` flits. `in_ready_o` for an input is 0 exactly while its buffer is full, and a flit offered while it is 0 is not taken. With the outputs blocked, an input accepts exactly `BUF_DEPTH` flits.
- R3: A packet's layer is drawn from a free-running LFSR. If the drawn layer has no eligible VC, the head waits and draws again on a later cycle. Over many packets from all inputs, each layer carries at least one eighth of the packets.
- R4: A packet is `PKT_LEN` flits. The first flit accepted on an idle input is its head. All its flits leave on one layer output with one VC value in `out_vc_o`, and within that layer and VC stream they appear in their original order with no other flit between them. Layer and VC stay fixed from head to tail.
- R5: A VC can be claimed by a new packet only when no packet currently holds it and its credit counter is at least `PKT_LEN`. A held VC is released when its tail flit is sent.
- R6: A flit goes out on a layer and VC only while that counter is nonzero. The counter decrements on each send and increments when `cr_valid_i` is 1 for that layer with `cr_vc_i` equal to the VC. The number of flits outstanding on any VC never exceeds `VC_DEPTH`.
- R7: Each layer output carries at most one flit per cycle, granted round-robin among requesting inputs. With no contention a packet's head appears at the output three cycles after it is offered to an empty input, and its remaining flits follow on consecutive cycles.
- R8: Packets from one input leave in the order they arrived. No flit is lost, duplicated or altered.
- R9: No two packets hold the same layer and VC at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_IN | Flit offered per tile input |
| in_flit_i | input | N_IN*FLIT_W | Flit data, input i in slice i |
| in_ready_o | output | N_IN | Input buffer can take a flit |
| out_valid_o | output | N_LAY | Flit sent to the layer router |
| out_flit_o | output | N_LAY*FLIT_W | Flit data, layer l in slice l |
| out_vc_o | output | N_LAY*log2(N_VC) | Downstream VC of the flit |
| cr_valid_i | input | N_LAY | One credit returned by the layer router |
| cr_vc_i | input | N_LAY*log2(N_VC) | VC the credit belongs to |

## Verification
The bench builds the block with its defaults: four inputs, four layers, four VCs per layer, 16-bit flits, five-flit packets, and buffers and VC depths of five. Because packet length equals VC depth, one packet uses up all credits of a VC. Sixteen packets sent without any credit returns therefore exhaust all sixteen VCs. The next packet on every input then stalls, which makes the buffer-full and allocation-gating cases easy to observe. Each flit carries its source, sequence number and index, so the bench can check ordering, stream integrity and per-layer load share at the outputs alone.

// File: rtl/lm_inj_pkg.sv
package lm_inj_pkg;
  localparam int LFSR_W = 32;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 32'h1ACE_B00C;

  // taps 32,22,2,1: maximal length
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction
endpackage

// File: rtl/lm_flit_fifo.sv
module lm_flit_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [W-1:0]               din_i,
  input  logic                       pop_i,
  output logic [W-1:0]               dout_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign dout_o  = mem_q[rd_q];
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/lm_rr_arb.sv
module lm_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, win;
  logic          hit;

  always_comb begin
    gnt_o = '0;
    hit   = 1'b0;
    win   = ptr_q;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!hit && req_i[idx]) begin
        hit = 1'b1;
        win = IW'(idx);
      end
    end
    if (hit) gnt_o[win] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ptr_q <= '0;
    else if (hit) ptr_q <= (win == IW'(N-1)) ? '0 : win + 1'b1;
  end
endmodule

// File: rtl/lm_inject_demux.sv
module lm_inject_demux
  import lm_inj_pkg::*;
#(
  parameter int N_IN      = 4,
  parameter int N_LAY     = 4,
  parameter int N_VC      = 4,
  parameter int FLIT_W    = 16,
  parameter int BUF_DEPTH = 5,
  parameter int PKT_LEN   = 5,
  parameter int VC_DEPTH  = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_IN-1:0]                 in_valid_i,
  input  logic [N_IN*FLIT_W-1:0]          in_flit_i,
  output logic [N_IN-1:0]                 in_ready_o,
  output logic [N_LAY-1:0]                out_valid_o,
  output logic [N_LAY*FLIT_W-1:0]         out_flit_o,
  output logic [N_LAY*$clog2(N_VC)-1:0]   out_vc_o,
  input  logic [N_LAY-1:0]                cr_valid_i,
  input  logic [N_LAY*$clog2(N_VC)-1:0]   cr_vc_i
);
  localparam int LW = (N_LAY > 1) ? $clog2(N_LAY) : 1;
  localparam int VW = $clog2(N_VC);
  localparam int CW = $clog2(VC_DEPTH+1);
  localparam int PW = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
  localparam int BW = $clog2(BUF_DEPTH+1);

  logic [FLIT_W-1:0] f_dout [N_IN];
  logic [N_IN-1:0]   f_empty, f_full, f_pop;
  logic [BW-1:0]     f_cnt [N_IN];

  logic [N_IN-1:0]   busy_q;
  logic [LW-1:0]     lay_q [N_IN];
  logic [VW-1:0]     vc_q  [N_IN];
  logic [PW-1:0]     cnt_q [N_IN];

  logic [N_VC-1:0]   owned_q [N_LAY];
  logic [CW-1:0]     cred_q  [N_LAY][N_VC];
  logic [N_VC-1:0]   cr_inc [N_LAY], cr_dec [N_LAY];

  logic [LFSR_W-1:0] lfsr_q;
  logic [LW-1:0]     pick [N_IN];

  logic [N_VC-1:0]   elig [N_LAY];
  logic [VW-1:0]     free_vc [N_LAY];
  logic [N_LAY-1:0]  any_free;

  logic [N_IN-1:0]   va_req [N_LAY], va_gnt [N_LAY];
  logic [N_IN-1:0]   sa_req [N_LAY], sa_gnt [N_LAY];

  logic [N_LAY-1:0]  snd_any, snd_tail;
  logic [VW-1:0]     snd_vc   [N_LAY];
  logic [FLIT_W-1:0] snd_flit [N_LAY];

  logic [N_LAY-1:0]  ov_q;
  logic [FLIT_W-1:0] of_q [N_LAY];
  logic [VW-1:0]     ovc_q [N_LAY];

  // flattened views for the bound checker
  logic [N_IN*LW-1:0] lay_flat;
  logic [N_IN*VW-1:0] vc_flat;
  logic [N_IN*BW-1:0] fcnt_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= LFSR_SEED;
    else         lfsr_q <= lfsr_step(lfsr_q);
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    lm_flit_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (in_valid_i[i]),
      .din_i   (in_flit_i[i*FLIT_W +: FLIT_W]),
      .pop_i   (f_pop[i]),
      .dout_o  (f_dout[i]),
      .empty_o (f_empty[i]),
      .full_o  (f_full[i]),
      .count_o (f_cnt[i])
    );
    assign in_ready_o[i] = !f_full[i];
    // each input reads its own LFSR slice
    assign pick[i] = LW'(int'(lfsr_q[(i*7) % (LFSR_W-LW) +: LW]) % N_LAY);
    assign lay_flat[i*LW +: LW]  = lay_q[i];
    assign vc_flat[i*VW +: VW]   = vc_q[i];
    assign fcnt_flat[i*BW +: BW] = f_cnt[i];
  end

  // VC eligibility: idle and room for a whole packet downstream
  always_comb begin
    for (int l = 0; l < N_LAY; l++) begin
      free_vc[l] = '0;
      for (int v = N_VC-1; v >= 0; v--) begin
        elig[l][v] = !owned_q[l][v] && (cred_q[l][v] >= CW'(PKT_LEN));
        if (elig[l][v]) free_vc[l] = VW'(v);
      end
      any_free[l] = |elig[l];
    end
  end

  always_comb begin
    for (int l = 0; l < N_LAY; l++) begin
      for (int i = 0; i < N_IN; i++) begin
        va_req[l][i] = !busy_q[i] && !f_empty[i] && (pick[i] == LW'(l)) && any_free[l];
        sa_req[l][i] = busy_q[i] && !f_empty[i] && (lay_q[i] == LW'(l))
                       && (cred_q[l][vc_q[i]] != '0);
      end
    end
  end

  for (genvar l = 0; l < N_LAY; l++) begin : g_lay
    lm_rr_arb #(.N(N_IN)) u_va (.clk_i(clk_i), .rst_ni(rst_ni), .req_i(va_req[l]), .gnt_o(va_gnt[l]));
    lm_rr_arb #(.N(N_IN)) u_sa (.clk_i(clk_i), .rst_ni(rst_ni), .req_i(sa_req[l]), .gnt_o(sa_gnt[l]));
    assign out_valid_o[l]                  = ov_q[l];
    assign out_flit_o[l*FLIT_W +: FLIT_W]  = of_q[l];
    assign out_vc_o[l*VW +: VW]            = ovc_q[l];
  end

  always_comb begin
    f_pop = '0;
    for (int l = 0; l < N_LAY; l++) begin
      snd_any[l]  = 1'b0;
      snd_tail[l] = 1'b0;
      snd_vc[l]   = '0;
      snd_flit[l] = '0;
      for (int i = 0; i < N_IN; i++) begin
        if (sa_gnt[l][i]) begin
          f_pop[i]    = 1'b1;
          snd_any[l]  = 1'b1;
          snd_vc[l]   = vc_q[i];
          snd_flit[l] = f_dout[i];
          snd_tail[l] = (cnt_q[i] == PW'(PKT_LEN-1));
        end
      end
      for (int v = 0; v < N_VC; v++) begin
        cr_dec[l][v] = snd_any[l] && (snd_vc[l] == VW'(v));
        cr_inc[l][v] = cr_valid_i[l] && (cr_vc_i[l*VW +: VW] == VW'(v));
      end
    end
  end

  // per-input packet state: route held from head to tail
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      for (int i = 0; i < N_IN; i++) begin
        lay_q[i] <= '0;
        vc_q[i]  <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_IN; i++) begin
        if (!busy_q[i]) begin
          for (int l = 0; l < N_LAY; l++) begin
            if (va_gnt[l][i]) begin
              busy_q[i] <= 1'b1;
              lay_q[i]  <= LW'(l);
              vc_q[i]   <= free_vc[l];
              cnt_q[i]  <= '0;
            end
          end
        end else if (f_pop[i]) begin
          if (cnt_q[i] == PW'(PKT_LEN-1)) busy_q[i] <= 1'b0;
          else                            cnt_q[i]  <= cnt_q[i] + 1'b1;
        end
      end
    end
  end

  // VC ownership, credits, output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q <= '0;
      for (int l = 0; l < N_LAY; l++) begin
        owned_q[l] <= '0;
        of_q[l]    <= '0;
        ovc_q[l]   <= '0;
        for (int v = 0; v < N_VC; v++) cred_q[l][v] <= CW'(VC_DEPTH);
      end
    end else begin
      ov_q <= snd_any;
      for (int l = 0; l < N_LAY; l++) begin
        of_q[l]  <= snd_flit[l];
        ovc_q[l] <= snd_vc[l];
        for (int v = 0; v < N_VC; v++) begin
          if ((|va_gnt[l]) && (free_vc[l] == VW'(v)))
            owned_q[l][v] <= 1'b1;
          else if (snd_tail[l] && cr_dec[l][v])
            owned_q[l][v] <= 1'b0;
          cred_q[l][v] <= cred_q[l][v] + CW'(cr_inc[l][v]) - CW'(cr_dec[l][v]);
        end
      end
    end
  end
endmodule

// File: rtl/lm_inject_demux_chk.sv
module lm_inject_demux_chk #(
  parameter int N_IN      = 4,
  parameter int N_LAY     = 4,
  parameter int N_VC      = 4,
  parameter int BUF_DEPTH = 5,
  parameter int VC_DEPTH  = 5,
  parameter int LW        = 2,
  parameter int VW        = 2,
  parameter int BW        = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [N_LAY-1:0]      out_valid_i,
  input logic [N_LAY*VW-1:0]   out_vc_i,
  input logic [N_LAY-1:0]      cr_valid_i,
  input logic [N_LAY*VW-1:0]   cr_vc_i,
  input logic [N_IN-1:0]       busy_i,
  input logic [N_IN*LW-1:0]    lay_i,
  input logic [N_IN*VW-1:0]    vc_i,
  input logic [N_IN*BW-1:0]    fcnt_i
);
  localparam int SW = $clog2(VC_DEPTH+1) + 1;

  // credits seen from the outside of the block
  logic [SW-1:0] sh_q [N_LAY][N_VC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < N_LAY; l++)
        for (int v = 0; v < N_VC; v++) sh_q[l][v] <= SW'(VC_DEPTH);
    end else begin
      for (int l = 0; l < N_LAY; l++)
        for (int v = 0; v < N_VC; v++)
          sh_q[l][v] <= sh_q[l][v]
            - SW'(out_valid_i[l] && (out_vc_i[l*VW +: VW] == VW'(v)))
            + SW'(cr_valid_i[l] && (cr_vc_i[l*VW +: VW] == VW'(v)));
    end
  end

  for (genvar l = 0; l < N_LAY; l++) begin : g_l
    for (genvar v = 0; v < N_VC; v++) begin : g_v
      a_r6_credit_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_i[l] && (out_vc_i[l*VW +: VW] == VW'(v))) |-> (sh_q[l][v] != '0));
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_i
    a_r2_buf_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fcnt_i[i*BW +: BW] <= BW'(BUF_DEPTH));
    a_r4_route_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i[i] && $past(busy_i[i])) |-> ($stable(lay_i[i*LW +: LW]) && $stable(vc_i[i*VW +: VW])));
    for (genvar j = 0; j < N_IN; j++) begin : g_j
      if (j > i) begin : g_pair
        a_r9_vc_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
          !(busy_i[i] && busy_i[j] && (lay_i[i*LW +: LW] == lay_i[j*LW +: LW])
            && (vc_i[i*VW +: VW] == vc_i[j*VW +: VW])));
      end
    end
  end
endmodule

bind lm_inject_demux lm_inject_demux_chk #(
  .N_IN(N_IN), .N_LAY(N_LAY), .N_VC(N_VC), .BUF_DEPTH(BUF_DEPTH),
  .VC_DEPTH(VC_DEPTH), .LW(LW), .VW(VW), .BW(BW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_valid_i (out_valid_o),
  .out_vc_i    (out_vc_o),
  .cr_valid_i  (cr_valid_i),
  .cr_vc_i     (cr_vc_i),
  .busy_i      (busy_q),
  .lay_i       (lay_flat),
  .vc_i        (vc_flat),
  .fcnt_i      (fcnt_flat)
);

// File: tb/lm_inject_demux_tb.sv
module lm_inject_demux_tb_top;
  localparam int N_IN = 4, N_LAY = 4, N_VC = 4, FW = 16;
  localparam int BUF_DEPTH = 5, PKT_LEN = 5, VC_DEPTH = 5;
  localparam int VW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N_IN-1:0]       in_valid = '0;
  logic [N_IN*FW-1:0]    in_flit  = '0;
  logic [N_IN-1:0]       in_ready;
  logic [N_LAY-1:0]      out_valid;
  logic [N_LAY*FW-1:0]   out_flit;
  logic [N_LAY*VW-1:0]   out_vc;
  logic [N_LAY-1:0]      cr_valid = '0;
  logic [N_LAY*VW-1:0]   cr_vc    = '0;

  lm_inject_demux #(
    .N_IN(N_IN), .N_LAY(N_LAY), .N_VC(N_VC), .FLIT_W(FW),
    .BUF_DEPTH(BUF_DEPTH), .PKT_LEN(PKT_LEN), .VC_DEPTH(VC_DEPTH)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_flit_i(in_flit), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_flit_o(out_flit), .out_vc_o(out_vc),
    .cr_valid_i(cr_valid), .cr_vc_i(cr_vc)
  );

  int checks = 0, errors = 0;
  int goal [N_IN], sent [N_IN], nxt_seq [N_IN];
  bit drv_v [N_IN], last_rdy [N_IN];
  int exp_idx [N_LAY][N_VC], cur_src [N_LAY][N_VC], cur_seq [N_LAY][N_VC];
  int outst [N_LAY][N_VC];
  int lay_pk [N_LAY];
  int delivered = 0;
  bit ret_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // flit = {src[15:14], seq[13:6], 3'b0, idx[2:0]}
  function automatic logic [FW-1:0] mk(input int src, input int n);
    return {2'(src), 8'(n / PKT_LEN), 3'b000, 3'(n % PKT_LEN)};
  endfunction

  // monitor, credit return, input driver
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < N_LAY; l++) begin
        if (out_valid[l]) begin
          int v, s, q, x;
          logic [FW-1:0] f;
          v = int'(out_vc[l*VW +: VW]);
          f = out_flit[l*FW +: FW];
          s = int'(f[15:14]); q = int'(f[13:6]); x = int'(f[2:0]);
          chk(x == exp_idx[l][v], "R4 flit index in VC stream", x, exp_idx[l][v]);
          if (x == 0) begin
            chk(q == nxt_seq[s], "R8 packet order per input", q, nxt_seq[s]);
            cur_src[l][v] = s; cur_seq[l][v] = q;
            lay_pk[l]++;
          end else begin
            chk(s == cur_src[l][v] && q == cur_seq[l][v], "R9 VC stream interleaved",
                s * 256 + q, cur_src[l][v] * 256 + cur_seq[l][v]);
          end
          if (x == PKT_LEN - 1) nxt_seq[s] = q + 1;
          exp_idx[l][v] = (x + 1) % PKT_LEN;
          outst[l][v]++;
          chk(outst[l][v] <= VC_DEPTH, "R6 credit overrun", outst[l][v], VC_DEPTH);
          delivered++;
        end
      end
      for (int l = 0; l < N_LAY; l++) begin
        cr_valid[l] = 1'b0;
        if (ret_on) begin
          for (int v = N_VC - 1; v >= 0; v--)
            if (outst[l][v] > 0) begin cr_valid[l] = 1'b1; cr_vc[l*VW +: VW] = VW'(v); end
          if (cr_valid[l]) outst[l][int'(cr_vc[l*VW +: VW])]--;
        end
      end
      for (int i = 0; i < N_IN; i++) begin
        if (drv_v[i] && last_rdy[i]) sent[i]++;
        if (sent[i] < goal[i]) begin
          in_valid[i] = 1'b1;
          in_flit[i*FW +: FW] = mk(i, sent[i]);
        end else in_valid[i] = 1'b0;
        drv_v[i] = in_valid[i];
        last_rdy[i] = in_ready[i];
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    ret_on = 0;
    @(posedge clk);
    delivered = 0;
    in_valid = '0; cr_valid = '0;
    for (int i = 0; i < N_IN; i++) begin
      goal[i] = 0; sent[i] = 0; nxt_seq[i] = 0; drv_v[i] = 0; last_rdy[i] = 0;
    end
    for (int l = 0; l < N_LAY; l++) begin
      lay_pk[l] = 0;
      for (int v = 0; v < N_VC; v++) begin
        exp_idx[l][v] = 0; outst[l][v] = 0; cur_src[l][v] = 0; cur_seq[l][v] = 0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_deliv(input int target, input int maxc);
    for (int k = 0; k < maxc && delivered < target; k++) @(negedge clk);
    @(negedge clk); #1;
  endtask

  task automatic t_reset_state();
    #1;
    chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == '1, "R1 in_ready after reset", int'(in_ready), 15);
  endtask

  // all 16 VCs consumed with no credit return, then stall
  task automatic t_credit_stall();
    for (int i = 0; i < N_IN; i++) goal[i] = 4 * PKT_LEN;
    wait_deliv(80, 600);
    chk(delivered == 80, "R1 R5 full credits serve one packet per VC", delivered, 80);
    for (int i = 0; i < N_IN; i++) goal[i] += PKT_LEN;
    repeat (40) @(negedge clk);
    #1;
    chk(delivered == 80, "R5 R6 no send without credits", delivered, 80);
    chk(in_ready == '0, "R2 in_ready low with full buffers", int'(in_ready), 0);
    for (int i = 0; i < N_IN; i++)
      chk(sent[i] == 4 * PKT_LEN + BUF_DEPTH, "R2 flits accepted when blocked", sent[i], 4 * PKT_LEN + BUF_DEPTH);
    ret_on = 1;
    wait_deliv(100, 600);
    chk(delivered == 100, "R6 credit return resumes flow", delivered, 100);
    chk(in_ready == '1, "R2 buffers drained", int'(in_ready), 15);
  endtask

  task automatic t_latency();
    int d0, d2, d7;
    ret_on = 1;
    repeat (10) @(negedge clk);
    @(posedge clk);
    d0 = delivered;
    goal[1] += PKT_LEN;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #1;
      if (k == 2) d2 = delivered;
      if (k == 7) d7 = delivered;
    end
    chk(d2 == d0, "R7 no output before third cycle", d2 - d0, 0);
    chk(d7 == d0 + PKT_LEN, "R7 packet streams on consecutive cycles", d7 - d0, PKT_LEN);
  endtask

  task automatic t_balance();
    int base [N_LAY];
    int tgt;
    ret_on = 1;
    for (int l = 0; l < N_LAY; l++) base[l] = lay_pk[l];
    for (int i = 0; i < N_IN; i++) goal[i] += 40 * PKT_LEN;
    tgt = delivered + N_IN * 40 * PKT_LEN;
    wait_deliv(tgt, 5000);
    chk(delivered == tgt, "R8 all flits delivered under load", delivered, tgt);
    for (int l = 0; l < N_LAY; l++)
      chk(lay_pk[l] - base[l] >= (N_IN * 40) / 8, "R3 layer share", lay_pk[l] - base[l], (N_IN * 40) / 8);
    for (int i = 0; i < N_IN; i++)
      chk(nxt_seq[i] == goal[i] / PKT_LEN, "R7 R8 every input progressed", nxt_seq[i], goal[i] / PKT_LEN);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_sim();
  end

  initial begin
    do_reset();
    t_reset_state();
    t_credit_stall();
    t_latency();
    t_balance();
    finish_sim();
  end
endmodule